// File: doc/BRIEF.md
# Store Space Address Decoder

The decoder sits between the processor's address bus and the store boards of a machine whose store space holds 64K words of 16 bits each. It has no paging and no virtual addressing. Each access carries a word address and a read or write strobe. Instruction fetches are also marked with a qualifier. From these the decoder raises exactly one chip select: general RAM, the bootstrap ROM or video store. For a ROM access it also produces the word offset inside the ROM.

The ROM occupies word addresses 0x3800 to 0x3FFF. Its first four words also answer at addresses 0x0000 to 0x0003, which gives fixed program entry points. Video store fills 0x4000 to 0x7FFF. High store from 0x8000 upward holds data only.

Code may be fetched only below 0x4000, because the program counter is 14 bits wide. A strap input reports that an extra store board is fitted. When the strap is set, the ROM and its low mirror are switched off and both ranges decode as plain RAM.

An access the decoder refuses gets no select, and it sets a registered error flag on the next clock edge. Refused accesses are a write into the enabled ROM, a fetch above the code range, and a strobe with both read and write high.

Top module: `store_map_decoder`

## Requirements
- R1: With the strap low, any legal access at 0x3800..0x3FFF asserts rom_sel_o alone, with rom_off_o = address - 0x3800 (0x000..0x7FF). A legal access here is a read, or a fetch.
- R2: With the strap low, a read or fetch at 0x0000..0x0003 asserts rom_sel_o alone, with rom_off_o equal to the address (0..3).
- R3: A data read or write at 0x4000..0x7FFF asserts vid_sel_o alone.
- R4: A data read or write at 0x0004..0x37FF or at 0x8000..0xFFFF asserts ram_sel_o alone. Fetches below 0x3800 other than at the mirror also select RAM.
- R5: With the strap high, reads and writes at 0x0000..0x0003 and at 0x3800..0x3FFF assert ram_sel_o alone, and no error is raised.
- R6: With the strap low, a write to 0x0000..0x0003 or to 0x3800..0x3FFF asserts no select and sets err_o in the following cycle.
- R7: A fetch (ifetch_i high) at 0x4000 or above asserts no select and sets err_o in the following cycle.
- R8: With rd_i and wr_i both low, no select is asserted and err_o is low in the following cycle, whatever the address, ifetch_i and the strap.
- R9: rd_i and wr_i high together assert no select and set err_o in the following cycle.
- R10: At most one select is high in any cycle, and rom_off_o is 0 whenever rom_sel_o is low.
- R11: err_o is 0 after reset. Each cycle it shows only whether the access of the previous cycle was refused, so it falls after a legal or idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Word address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ifetch_i | input | 1 | Access is an instruction fetch |
| ext_board_i | input | 1 | Extra store board fitted; disables ROM |
| ram_sel_o | output | 1 | RAM chip select (combinational) |
| rom_sel_o | output | 1 | ROM chip select (combinational) |
| vid_sel_o | output | 1 | Video store chip select (combinational) |
| rom_off_o | output | 11 | Word offset inside the ROM |
| err_o | output | 1 | Refused access in the previous cycle (registered) |

## Verification
On every cycle the assertions check that at most one select is high and that the ROM offset is idle without a ROM select. They also check that idle cycles, protected ROM writes and out-of-range fetches raise no select. For these cases they check the error flag on the next edge, and they check that video reads and strapped ROM reads land in the right store. The exact offsets across the ROM and the mirror, the range edges at 0x0003/0x0004, 0x37FF/0x3800 and 0x3FFF/0x4000/0x7FFF/0x8000, and the way the error flag clears after a refused access are shown only by the bench's directed scenarios.

// File: rtl/store_map_pkg.sv
package store_map_pkg;
  typedef enum logic [2:0] {
    REG_LOW,
    REG_MIRROR,
    REG_ROM,
    REG_VID,
    REG_HIGH
  } region_e;

  typedef struct packed {
    logic ram;
    logic rom;
    logic vid;
  } sel_t;
endpackage

// File: rtl/store_region_classify.sv
module store_region_classify
  import store_map_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int ROM_BASE     = 'h3800,
  parameter int ROM_WORDS    = 'h0800,
  parameter int MIRROR_WORDS = 4,
  parameter int VID_BASE     = 'h4000,
  parameter int VID_WORDS    = 'h4000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rom_en_i,
  output region_e           region_o
);
  localparam logic [ADDR_W:0] RomLo  = (ADDR_W+1)'(ROM_BASE);
  localparam logic [ADDR_W:0] RomHi  = (ADDR_W+1)'(ROM_BASE + ROM_WORDS);
  localparam logic [ADDR_W:0] MirHi  = (ADDR_W+1)'(MIRROR_WORDS);
  localparam logic [ADDR_W:0] VidLo  = (ADDR_W+1)'(VID_BASE);
  localparam logic [ADDR_W:0] HighLo = (ADDR_W+1)'(VID_BASE + VID_WORDS);

  logic [ADDR_W:0] a;
  assign a = {1'b0, addr_i};

  always_comb begin
    if (a >= HighLo)                              region_o = REG_HIGH;
    else if (a >= VidLo)                          region_o = REG_VID;
    else if (rom_en_i && a >= RomLo && a < RomHi) region_o = REG_ROM;
    else if (rom_en_i && a < MirHi)               region_o = REG_MIRROR;
    else                                          region_o = REG_LOW;
  end
endmodule

// File: rtl/store_access_check.sv
module store_access_check
  import store_map_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int FETCH_TOP = 'h4000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  region_e           region_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              ifetch_i,
  output logic              grant_o,
  output logic              refuse_o
);
  localparam logic [ADDR_W:0] FetchHi = (ADDR_W+1)'(FETCH_TOP);

  logic access, both, wp_hit, fetch_bad;

  always_comb begin
    access    = rd_i | wr_i;
    both      = rd_i & wr_i;
    wp_hit    = wr_i && (region_i == REG_ROM || region_i == REG_MIRROR);
    fetch_bad = ifetch_i && ({1'b0, addr_i} >= FetchHi);
    refuse_o  = access & (both | wp_hit | fetch_bad);
    grant_o   = access & ~refuse_o;
  end
endmodule

// File: rtl/store_sel_encode.sv
module store_sel_encode
  import store_map_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ROM_BASE = 'h3800,
  parameter int OFF_W    = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  region_e           region_i,
  input  logic              grant_i,
  output sel_t              sel_o,
  output logic [OFF_W-1:0]  rom_off_o
);
  always_comb begin
    sel_o     = '0;
    rom_off_o = '0;
    if (grant_i) begin
      unique case (region_i)
        REG_ROM: begin
          sel_o.rom = 1'b1;
          rom_off_o = OFF_W'(addr_i - ADDR_W'(ROM_BASE));
        end
        REG_MIRROR: begin
          sel_o.rom = 1'b1;
          rom_off_o = OFF_W'(addr_i);
        end
        REG_VID:  sel_o.vid = 1'b1;
        default:  sel_o.ram = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/store_err_reg.sv
module store_err_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic refuse_i,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= refuse_i;
  end
endmodule

// File: rtl/store_map_decoder.sv
module store_map_decoder
  import store_map_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int ROM_BASE     = 'h3800,
  parameter int ROM_WORDS    = 'h0800,
  parameter int MIRROR_WORDS = 4,
  parameter int VID_BASE     = 'h4000,
  parameter int VID_WORDS    = 'h4000,
  parameter int FETCH_TOP    = 'h4000,
  localparam int OFF_W       = $clog2(ROM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             ifetch_i,
  input  logic             ext_board_i,
  output logic             ram_sel_o,
  output logic             rom_sel_o,
  output logic             vid_sel_o,
  output logic [OFF_W-1:0] rom_off_o,
  output logic             err_o
);
  region_e region;
  logic    grant, refuse;
  sel_t    sel;

  store_region_classify #(
    .ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_WORDS(ROM_WORDS),
    .MIRROR_WORDS(MIRROR_WORDS), .VID_BASE(VID_BASE), .VID_WORDS(VID_WORDS)
  ) u_classify (
    .addr_i  (addr_i),
    .rom_en_i(~ext_board_i),
    .region_o(region)
  );

  store_access_check #(.ADDR_W(ADDR_W), .FETCH_TOP(FETCH_TOP)) u_check (
    .addr_i  (addr_i),
    .region_i(region),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .ifetch_i(ifetch_i),
    .grant_o (grant),
    .refuse_o(refuse)
  );

  store_sel_encode #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .OFF_W(OFF_W)) u_encode (
    .addr_i   (addr_i),
    .region_i (region),
    .grant_i  (grant),
    .sel_o    (sel),
    .rom_off_o(rom_off_o)
  );

  store_err_reg u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .refuse_i(refuse),
    .err_o   (err_o)
  );

  assign ram_sel_o = sel.ram;
  assign rom_sel_o = sel.rom;
  assign vid_sel_o = sel.vid;
endmodule

// File: rtl/store_map_decoder_chk.sv
module store_map_decoder_chk #(
  parameter int ADDR_W       = 16,
  parameter int ROM_BASE     = 'h3800,
  parameter int ROM_WORDS    = 'h0800,
  parameter int MIRROR_WORDS = 4,
  parameter int VID_BASE     = 'h4000,
  parameter int VID_WORDS    = 'h4000,
  parameter int FETCH_TOP    = 'h4000,
  parameter int OFF_W        = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              ifetch_i,
  input logic              ext_board_i,
  input logic              ram_sel_o,
  input logic              rom_sel_o,
  input logic              vid_sel_o,
  input logic [OFF_W-1:0]  rom_off_o,
  input logic              err_o
);
  logic [ADDR_W:0] a;
  logic in_rom, in_vid, hi_fetch, no_sel;
  assign a        = {1'b0, addr_i};
  assign in_rom   = (a >= (ADDR_W+1)'(ROM_BASE) && a < (ADDR_W+1)'(ROM_BASE + ROM_WORDS))
                  || a < (ADDR_W+1)'(MIRROR_WORDS);
  assign in_vid   = a >= (ADDR_W+1)'(VID_BASE) && a < (ADDR_W+1)'(VID_BASE + VID_WORDS);
  assign hi_fetch = ifetch_i && a >= (ADDR_W+1)'(FETCH_TOP);
  assign no_sel   = !ram_sel_o && !rom_sel_o && !vid_sel_o;

  // R10
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_sel_o, rom_sel_o, vid_sel_o}));
  // R10
  rom_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_sel_o |-> rom_off_o == '0);
  // R6
  rom_wp_nosel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ext_board_i && in_rom) |-> no_sel);
  // R6
  rom_wp_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ext_board_i && in_rom) |=> err_o);
  // R7
  fetch_nosel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_fetch |-> no_sel);
  // R7
  fetch_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_fetch && (rd_i || wr_i)) |=> err_o);
  // R8
  idle_nosel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |-> no_sel);
  // R8
  idle_noerr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> !err_o);
  // R3
  vid_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !ifetch_i && in_vid) |-> vid_sel_o);
  // R5
  strap_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_board_i && rd_i && !wr_i && in_rom) |-> ram_sel_o);
endmodule

bind store_map_decoder store_map_decoder_chk #(
  .ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_WORDS(ROM_WORDS),
  .MIRROR_WORDS(MIRROR_WORDS), .VID_BASE(VID_BASE), .VID_WORDS(VID_WORDS),
  .FETCH_TOP(FETCH_TOP), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/store_map_decoder_tb.sv
module store_map_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0, ifetch_i = 1'b0, ext_board_i = 1'b0;
  logic        ram_sel_o, rom_sel_o, vid_sel_o, err_o;
  logic [10:0] rom_off_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  store_map_decoder u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input bit r, input bit w, input bit f, input bit e);
    @(negedge clk_i);
    addr_i = a; rd_i = r; wr_i = w; ifetch_i = f; ext_board_i = e;
    #1;
  endtask

  // sel = {ram,rom,vid}
  task automatic chk_sel(input string tag, input logic [2:0] es, input logic [10:0] eoff);
    logic [2:0] s;
    s = {ram_sel_o, rom_sel_o, vid_sel_o};
    chk(s == es && rom_off_o == eoff, tag,
        $sformatf("sel=%b off=%h @%h", s, rom_off_o, addr_i),
        $sformatf("sel=%b off=%h", es, eoff));
  endtask

  task automatic chk_err(input string tag, input bit ee);
    @(posedge clk_i); #1;
    chk(err_o == ee, tag, $sformatf("err=%b", err_o), $sformatf("err=%b", ee));
  endtask

  task automatic t_reset;
    #1;
    chk(err_o == 1'b0, "R11 reset", $sformatf("err=%b", err_o), "err=0");
    drive(16'h3800, 1, 0, 0, 0);
    chk_sel("R8 in reset rom read", 3'b010, 11'h000);
  endtask

  task automatic t_rom;
    drive(16'h3800, 1, 0, 0, 0); chk_sel("R1 rom base", 3'b010, 11'h000); chk_err("R1 err", 0);
    drive(16'h3abc, 1, 0, 1, 0); chk_sel("R1 rom fetch", 3'b010, 11'h2bc);
    drive(16'h3fff, 1, 0, 0, 0); chk_sel("R1 rom top", 3'b010, 11'h7ff);
    drive(16'h37ff, 1, 0, 0, 0); chk_sel("R4 below rom", 3'b100, 11'h000);
  endtask

  task automatic t_mirror;
    for (int i = 0; i < 4; i++) begin
      drive(16'(i), 1, 0, 1, 0); chk_sel("R2 mirror", 3'b010, 11'(i));
    end
    drive(16'h0004, 1, 0, 1, 0); chk_sel("R4 past mirror", 3'b100, 11'h000);
  endtask

  task automatic t_video;
    drive(16'h4000, 1, 0, 0, 0); chk_sel("R3 vid base rd", 3'b001, 11'h000);
    drive(16'h7fff, 0, 1, 0, 0); chk_sel("R3 vid top wr", 3'b001, 11'h000);
    chk_err("R3 no err", 0);
  endtask

  task automatic t_ram;
    drive(16'h8000, 1, 0, 0, 0); chk_sel("R4 high base", 3'b100, 11'h000);
    drive(16'hffff, 0, 1, 0, 0); chk_sel("R4 high top wr", 3'b100, 11'h000);
    drive(16'h1234, 0, 1, 0, 0); chk_sel("R4 low wr", 3'b100, 11'h000);
    chk_err("R4 no err", 0);
  endtask

  task automatic t_strap;
    drive(16'h3900, 0, 1, 0, 1); chk_sel("R5 strap rom wr", 3'b100, 11'h000);
    chk_err("R5 strap no err", 0);
    drive(16'h0002, 1, 0, 1, 1); chk_sel("R5 strap mirror", 3'b100, 11'h000);
    drive(16'h0001, 0, 1, 0, 1); chk_sel("R5 strap mirror wr", 3'b100, 11'h000);
    chk_err("R5 strap mirror no err", 0);
  endtask

  task automatic t_wprot;
    drive(16'h3c00, 0, 1, 0, 0); chk_sel("R6 rom wr nosel", 3'b000, 11'h000);
    chk_err("R6 rom wr err", 1);
    drive(16'h0003, 0, 1, 0, 0); chk_sel("R6 mirror wr nosel", 3'b000, 11'h000);
    chk_err("R6 mirror wr err", 1);
  endtask

  task automatic t_fetch;
    drive(16'h3fff, 1, 0, 1, 0); chk_sel("R7 fetch edge ok", 3'b010, 11'h7ff);
    chk_err("R7 fetch edge no err", 0);
    drive(16'h4000, 1, 0, 1, 0); chk_sel("R7 fetch vid", 3'b000, 11'h000);
    chk_err("R7 fetch vid err", 1);
    drive(16'hc000, 1, 0, 1, 1); chk_sel("R7 fetch high", 3'b000, 11'h000);
    chk_err("R7 fetch high err", 1);
  endtask

  task automatic t_idle;
    drive(16'h3800, 0, 0, 1, 0); chk_sel("R8 idle rom", 3'b000, 11'h000);
    chk_err("R8 idle no err", 0);
    drive(16'h9000, 0, 0, 1, 1); chk_sel("R8 idle fetch high", 3'b000, 11'h000);
    chk_err("R8 idle high no err", 0);
  endtask

  task automatic t_both;
    drive(16'h1000, 1, 1, 0, 0); chk_sel("R9 rd+wr nosel", 3'b000, 11'h000);
    chk_err("R9 rd+wr err", 1);
  endtask

  task automatic t_clear;
    drive(16'h3801, 0, 1, 0, 0); chk_err("R11 set", 1);
    drive(16'h0100, 1, 0, 0, 0); chk_err("R11 clear after legal", 0);
    drive(16'h5000, 1, 0, 1, 0); chk_err("R11 set again", 1);
    drive(16'h5000, 0, 0, 0, 0); chk_err("R11 clear after idle", 0);
  endtask

  initial begin
    t_reset;
    @(negedge clk_i); rst_ni = 1'b1;
    t_rom;
    t_mirror;
    t_video;
    t_ram;
    t_strap;
    t_wprot;
    t_fetch;
    t_idle;
    t_both;
    t_clear;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule